// File: doc/BRIEF.md
# Pulse-Spreading PWM Generator

This block drives one PWM output whose frame length is a power of two between 512 and 65536 clock cycles. In normal mode each frame holds one high pulse whose length is the programmed duty count. In spreading mode the frame is cut into 2, 4 or 8 equal slots. The duty count is shared out over the slots, so the output toggles several times per frame at the same average level. This raises the ripple frequency that a downstream filter sees.

A host loads three local registers through one write port: the duty count, a configuration word and a start delay. A two-bit select picks which register receives the write. The duty count, resolution and slot count are copied into working registers only at a frame boundary, so a change never cuts a pulse short. Setting the enable bit starts a wait of the programmed delay and then a frame counter from zero. Clearing it forces the output to its idle level. An invert bit flips the output polarity.

Top module: `pwm_spread`

## Requirements
- R1: The configuration resolution field (bits 4:2, code c) sets the frame length to 2^N cycles with N = 9 + c. With the spreading field at 00, each frame is D high cycles from the frame start, followed by low cycles until the frame ends. D is the duty count.
- R2: The configuration spreading field (bits 6:5) selects 1, 2, 4 or 8 slots for codes 00, 01, 10 and 11. Each slot is 2^N divided by the slot count S cycles long. The high cycles of a slot form one run that starts at the slot's first cycle.
- R3: Let q = D div S and r = D mod S. Slot k, counted from 0 at the frame start, is high for q+1 cycles when k < r and for q cycles otherwise.
- R4: A duty of 0 keeps the output at its idle level for the whole frame. A duty of 2^N-1 leaves exactly one idle cycle per frame. Duty bits at or above bit N are ignored.
- R5: A duty write that arrives during a frame does not change that frame. It takes effect from the next frame onward.
- R6: The write select routes data as follows: 00 writes the duty register, 01 writes the configuration register, and 10 or 11 writes the delay register (bits 7:0).
- R7: Configuration bit 0 is the enable. Once a write sets it, the frame counter starts from zero. The first cycle of the first frame appears on the output d+2 cycles after the write's clock edge, where d is the delay. Before that the output stays at the idle level. Rewriting the configuration with the enable clear and then set restarts the output from a fresh frame.
- R8: The delay register holds d from 0 to 255. It shifts the start of the first frame after enable by d cycles.
- R9: Configuration bit 1 inverts the output, so the idle level becomes high. While the enable is clear, the output equals the invert bit from the second clock edge after the write.
- R10: After reset all local registers are zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the local registers |
| wr_sel | input | 2 | Local register select (00 duty, 01 configuration, 1x delay) |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Registered PWM output |

## Verification
A write is captured at one clock edge. Because the counter and the output are both registered, output sample i of the first frame is due i+d+2 edges after the enabling write. A disable or an invert change shows two edges after its write. The bench drives writes at falling edges and samples at falling edges. It skips exactly d+1 falling edges after the enabling write, checks that the output is still idle there, and then reads the frame cycle by cycle. Any one-cycle error in the delay or in a slot boundary therefore changes a measured slot count. A duty update is issued at a known sample index inside a frame, and that frame and the next frame are each checked against their own duty.

// File: rtl/pwm_spread_pkg.sv
package pwm_spread_pkg;

  localparam int RES_CODE_W = 3;
  localparam int SPR_W      = 2;

  typedef struct packed {
    logic [SPR_W-1:0]      spread;
    logic [RES_CODE_W-1:0] res;
    logic                  inv;
    logic                  en;
  } pwm_cfg_t;

  localparam int CFG_W = $bits(pwm_cfg_t);

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_spread_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] duty_q,
  output pwm_cfg_t          cfg_q,
  output logic [DLY_W-1:0]  dly_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= '0;
      cfg_q  <= '0;
      dly_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel[1])      dly_q  <= wr_data[DLY_W-1:0];
      else if (wr_sel[0]) cfg_q  <= pwm_cfg_t'(wr_data[CFG_W-1:0]);
      else                duty_q <= wr_data;
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_spread_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DLY_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [RES_CODE_W-1:0] res_in,
  input  logic [SPR_W-1:0]      spread_in,
  input  logic [CNT_W-1:0]      duty_in,
  input  logic [DLY_W-1:0]      dly,
  output logic                  run,
  output logic [CNT_W-1:0]      cnt,
  output logic [CNT_W-1:0]      act_duty,
  output logic [RES_CODE_W-1:0] act_res,
  output logic [SPR_W-1:0]      act_spread,
  output logic [CNT_W-1:0]      frame_mask
);

  logic [DLY_W-1:0]      wait_cnt;
  logic [RES_CODE_W-1:0] res_gap;

  // Unused top resolution bits are cleared from an all-ones mask.
  assign res_gap    = ~act_res;
  assign frame_mask = {CNT_W{1'b1}} >> res_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      wait_cnt   <= '0;
      cnt        <= '0;
      act_duty   <= '0;
      act_res    <= '0;
      act_spread <= '0;
    end else if (!en) begin
      run      <= 1'b0;
      wait_cnt <= '0;
      cnt      <= '0;
    end else if (!run) begin
      if (wait_cnt == dly) begin
        run        <= 1'b1;
        cnt        <= '0;
        act_duty   <= duty_in;
        act_res    <= res_in;
        act_spread <= spread_in;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end else if (cnt == frame_mask) begin
      cnt        <= '0;
      act_duty   <= duty_in;
      act_res    <= res_in;
      act_spread <= spread_in;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_shaper.sv
module pwm_shaper
  import pwm_spread_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_RES = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  inv,
  input  logic                  run,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [CNT_W-1:0]      act_duty,
  input  logic [RES_CODE_W-1:0] act_res,
  input  logic [SPR_W-1:0]      act_spread,
  input  logic [CNT_W-1:0]      frame_mask,
  output logic                  pwm_out
);

  localparam int SH_W = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] duty_eff;
  logic [CNT_W-1:0] quota;
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] slot_idx;
  logic [SH_W-1:0]  slot_sh;
  logic             bonus;
  logic [CNT_W:0]   limit;
  logic             hi;

  assign duty_eff = act_duty & frame_mask;
  assign quota    = duty_eff >> act_spread;
  assign rem      = duty_eff & ~({CNT_W{1'b1}} << act_spread);
  assign slot_sh  = SH_W'(MIN_RES) + SH_W'(act_res) - SH_W'(act_spread);
  assign slot_idx = cnt >> slot_sh;
  assign pos      = cnt & (frame_mask >> act_spread);
  assign bonus    = (slot_idx < rem);
  assign limit    = {1'b0, quota} + {{CNT_W{1'b0}}, bonus};
  assign hi       = run && ({1'b0, pos} < limit);

  always_ff @(posedge clk) begin
    if (rst)      pwm_out <= 1'b0;
    else if (!en) pwm_out <= inv;
    else          pwm_out <= hi ^ inv;
  end

endmodule

// File: rtl/pwm_spread.sv
module pwm_spread
  import pwm_spread_pkg::*;
#(
  parameter int MIN_RES = 9,
  parameter int DLY_W   = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [15:0] wr_data,
  output logic        pwm_out
);

  localparam int CNT_W = MIN_RES + (2 ** RES_CODE_W) - 1;

  logic [CNT_W-1:0]      duty_q;
  pwm_cfg_t              cfg_q;
  logic [DLY_W-1:0]      dly_q;
  logic                  cfg_en;
  logic                  cfg_inv;
  logic                  run;
  logic [CNT_W-1:0]      cnt;
  logic [CNT_W-1:0]      act_duty;
  logic [RES_CODE_W-1:0] act_res;
  logic [SPR_W-1:0]      act_spread;
  logic [CNT_W-1:0]      frame_mask;

  assign cfg_en  = cfg_q.en;
  assign cfg_inv = cfg_q.inv;

  pwm_regs #(.DATA_W(CNT_W), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data[CNT_W-1:0]),
    .duty_q(duty_q), .cfg_q(cfg_q), .dly_q(dly_q)
  );

  pwm_timebase #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_tb (
    .clk(clk), .rst(rst), .en(cfg_en), .res_in(cfg_q.res),
    .spread_in(cfg_q.spread), .duty_in(duty_q), .dly(dly_q),
    .run(run), .cnt(cnt), .act_duty(act_duty), .act_res(act_res),
    .act_spread(act_spread), .frame_mask(frame_mask)
  );

  pwm_shaper #(.CNT_W(CNT_W), .MIN_RES(MIN_RES)) u_shp (
    .clk(clk), .rst(rst), .en(cfg_en), .inv(cfg_inv), .run(run),
    .cnt(cnt), .act_duty(act_duty), .act_res(act_res),
    .act_spread(act_spread), .frame_mask(frame_mask), .pwm_out(pwm_out)
  );

endmodule

// File: rtl/pwm_spread_chk.sv
module pwm_spread_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pwm_out,
  input logic             cfg_en,
  input logic             cfg_inv,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_duty,
  input logic [CNT_W-1:0] frame_mask
);

  AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    run |-> ((cnt & ~frame_mask) == '0)); // R1

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && cfg_en && cnt == frame_mask) |=> (cnt == '0)); // R1

  AST_RUN_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (cnt == '0)); // R7

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && cnt != '0) |-> $stable(act_duty)); // R5

  AST_OFF_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (pwm_out == $past(cfg_inv))); // R9

  AST_ZERO_DUTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && (act_duty & frame_mask) == '0) |=> (pwm_out == $past(cfg_inv))); // R4

endmodule

bind pwm_spread pwm_spread_chk u_chk (
  .clk(clk), .rst(rst), .pwm_out(pwm_out), .cfg_en(cfg_en),
  .cfg_inv(cfg_inv), .run(run), .cnt(cnt), .act_duty(act_duty),
  .frame_mask(frame_mask)
);

// File: tb/tb_pwm_spread.sv
module tb_pwm_spread;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'b00;
  logic [15:0] wr_data = 16'h0000;
  logic        pwm_out;

  int n_checks = 0;
  int n_errors = 0;

  pwm_spread dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 190000);
    n_errors++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cfgw(input bit en, input bit inv,
                                       input int res, input int sp);
    logic [15:0] w;
    w = 16'h0000;
    w[0]   = en;
    w[1]   = inv;
    w[4:2] = res[2:0];
    w[6:5] = sp[1:0];
    return w;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Loads all registers, enables, and checks the output is idle at the last delay cycle.
  task automatic start(input int res, input int sp, input bit inv, input int d,
                       input logic [15:0] duty, input logic [1:0] dsel, input string tag);
    wr(2'b01, cfgw(1'b0, inv, res, sp));
    wr(2'b00, duty);
    wr(dsel, d[15:0]);
    wr(2'b01, cfgw(1'b1, inv, res, sp));
    repeat (d) @(negedge clk);
    @(negedge clk);
    check(pwm_out == inv, {tag, " idle before first frame"}, int'(pwm_out), int'(inv));
  endtask

  // Samples one full frame and checks each slot's high run.
  task automatic measure(input int res, input int sp, input bit inv,
                         input logic [15:0] duty, input int wr_at,
                         input logic [15:0] newd, input string tag);
    int n_len = 1 << (9 + res);
    int s_cnt = 1 << sp;
    int l_len = n_len / s_cnt;
    int dm = int'(duty) & (n_len - 1);
    int hi [8];
    int lead [8];
    bit cont [8];
    for (int k = 0; k < 8; k++) begin
      hi[k] = 0; lead[k] = 0; cont[k] = 1'b0;
    end
    for (int i = 0; i < n_len; i++) begin
      int k;
      int p;
      bit lvl;
      @(negedge clk);
      if (i == wr_at + 1) wr_en = 1'b0;
      lvl = pwm_out ^ inv;
      k = i / l_len;
      p = i % l_len;
      if (p == 0) cont[k] = 1'b1;
      if (lvl) begin
        hi[k]++;
        if (cont[k]) lead[k]++;
      end else begin
        cont[k] = 1'b0;
      end
      if (i == wr_at) begin
        wr_en = 1'b1; wr_sel = 2'b00; wr_data = newd;
      end
    end
    for (int k = 0; k < s_cnt; k++) begin
      int e = (dm >> sp) + ((k < (dm & (s_cnt - 1))) ? 1 : 0);
      check(hi[k] == e && lead[k] == e,
            $sformatf("%s slot %0d high run", tag, k), hi[k] * 100000 + lead[k], e * 100000 + e);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(pwm_out == 1'b0, "R10 output after reset", int'(pwm_out), 0);
    repeat (5) @(negedge clk);
    check(pwm_out == 1'b0, "R10 output stays low while disabled", int'(pwm_out), 0);
  endtask

  task automatic t_normal();
    start(0, 0, 1'b0, 0, 16'd128, 2'b10, "R1 R7");
    measure(0, 0, 1'b0, 16'd128, -1, 16'd0, "R1 9-bit duty 128");
    measure(0, 0, 1'b0, 16'd128, -1, 16'd0, "R1 second frame");
  endtask

  task automatic t_spread();
    start(1, 3, 1'b0, 0, 16'd892, 2'b10, "R2");
    measure(1, 3, 1'b0, 16'd892, -1, 16'd0, "R3 10-bit 8 slots 112/111");
    start(0, 1, 1'b0, 5, 16'd301, 2'b10, "R2 R8");
    measure(0, 1, 1'b0, 16'd301, -1, 16'd0, "R2 two slots odd duty");
    start(0, 2, 1'b0, 0, 16'd301, 2'b10, "R2");
    measure(0, 2, 1'b0, 16'd301, -1, 16'd0, "R3 four slots remainder 1");
    start(3, 3, 1'b0, 0, 16'd1000, 2'b10, "R1");
    measure(3, 3, 1'b0, 16'd1000, -1, 16'd0, "R1 R3 12-bit 8 slots");
  endtask

  task automatic t_bounds();
    start(0, 0, 1'b0, 0, 16'd0, 2'b10, "R4");
    measure(0, 0, 1'b0, 16'd0, -1, 16'd0, "R4 zero duty");
    start(0, 3, 1'b0, 0, 16'd511, 2'b10, "R4");
    measure(0, 3, 1'b0, 16'd511, -1, 16'd0, "R4 full duty one idle cycle");
    start(0, 0, 1'b0, 0, 16'hFE80, 2'b10, "R4");
    measure(0, 0, 1'b0, 16'hFE80, -1, 16'd0, "R4 upper duty bits ignored");
  endtask

  task automatic t_delay_sel();
    start(0, 2, 1'b0, 37, 16'd200, 2'b11, "R6 R8 select 11 delay 37");
    measure(0, 2, 1'b0, 16'd200, -1, 16'd0, "R6 R8 delay via select 11");
    start(0, 0, 1'b0, 255, 16'd60, 2'b10, "R8 delay 255");
    measure(0, 0, 1'b0, 16'd60, -1, 16'd0, "R8 maximum delay");
  endtask

  task automatic t_shadow();
    start(0, 0, 1'b0, 0, 16'd128, 2'b10, "R5");
    measure(0, 0, 1'b0, 16'd128, 200, 16'd300, "R5 frame keeps old duty");
    measure(0, 0, 1'b0, 16'd300, -1, 16'd0, "R5 next frame new duty");
  endtask

  task automatic t_invert_disable();
    start(1, 1, 1'b1, 3, 16'd333, 2'b10, "R9");
    measure(1, 1, 1'b1, 16'd333, -1, 16'd0, "R9 inverted output");
    wr(2'b01, cfgw(1'b0, 1'b1, 1, 1));
    @(negedge clk);
    check(pwm_out == 1'b1, "R9 disabled inverted idle high", int'(pwm_out), 1);
    repeat (20) @(negedge clk);
    check(pwm_out == 1'b1, "R9 disabled stays idle high", int'(pwm_out), 1);
    wr(2'b01, cfgw(1'b0, 1'b0, 1, 1));
    @(negedge clk);
    check(pwm_out == 1'b0, "R9 disabled idle low", int'(pwm_out), 0);
  endtask

  task automatic t_restart();
    start(0, 0, 1'b0, 0, 16'd100, 2'b10, "R7");
    repeat (50) @(negedge clk);
    start(0, 1, 1'b0, 2, 16'd100, 2'b10, "R7 restart");
    measure(0, 1, 1'b0, 16'd100, -1, 16'd0, "R7 restart from fresh frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_normal();
    t_spread();
    t_bounds();
    t_delay_sel();
    t_shadow();
    t_invert_disable();
    t_restart();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule